// File: doc/BRIEF.md
# DDR Mode Register and Read Latency Controller

This block sits in a DDR-style memory device model or controller. It watches load-mode-register commands on an address bus and classifies each one as a normal-mode load, a DLL-reset load or a reserved encoding. It keeps the burst length, the burst type and the CAS latency from the last accepted load. A reserved encoding is reported as an error and leaves the stored settings untouched.

The block runs on a clock at twice the memory clock rate, so one tick is one half memory cycle. A CAS latency of 2 memory clocks is therefore 4 ticks, and a latency of 2.5 is 5 ticks. After a READ command the block raises a read-data-valid strobe once that many ticks have passed. The strobe stays high for one tick per data beat. A speed flag compares a supplied memory clock frequency against the limit for the stored latency. The analog DLL and the data path are outside the block.

Top module: `ddr_mode_ctl`

## Requirements
- R1: After a synchronous active-low reset the outputs show 4-beat sequential bursts and a CAS latency of 2 (`cas_half`=4, `cas_frac`=0). `rd_valid`, `mode_err`, `dll_rst_req` and `dll_rst_pend` are all 0.
- R2: A load with address bits ADDR_W-1..7 all zero and valid fields is a normal load, and it updates the settings on the tick after it is sampled. Bits 2:0 select burst length (001=2, 010=4, 011=8). Bit 3 selects the burst type (1=interleaved). Bits 6:4 select CAS latency (010=2, 110=2.5).
- R3: A load with bit 8 set and every other bit from 7 upward clear is a DLL-reset load. It updates the settings in the same way as a normal load, pulses `dll_rst_req` for exactly one tick, and sets `dll_rst_pend`.
- R4: `dll_rst_pend` is cleared only by a later accepted normal load. Reserved loads leave it unchanged.
- R5: Any other pattern in bits ADDR_W-1..7 is reserved. It pulses `mode_err` for one tick and leaves all settings unchanged.
- R6: A load whose burst-length code or latency code is not one of the listed values is also reserved. It pulses `mode_err`, changes nothing, and never pulses `dll_rst_req`.
- R7: `cas_half` reads 4 at latency 2 and 5 at latency 2.5. `cas_frac` is 1 only at latency 2.5.
- R8: When `rd_cmd` is sampled at tick edge n, `rd_valid` first reads 1 right after edge n + `cas_half`.
- R9: `rd_valid` stays high for exactly `burst_beats` ticks per READ and then falls.
- R10: `speed_err` is 1 when `freq_mhz` exceeds 133 at latency 2, or exceeds 167 at latency 2.5.
- R11: A second READ sampled `burst_beats` ticks after the first extends `rd_valid` with no gap, for a total of 2×`burst_beats` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, twice the memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lmr_valid | input | 1 | Load-mode-register command strobe |
| lmr_addr | input | ADDR_W | Address bus carrying the mode word |
| rd_cmd | input | 1 | READ command strobe |
| freq_mhz | input | FREQ_W | Memory clock frequency in MHz |
| burst_beats | output | 4 | Stored burst length in beats (2, 4 or 8) |
| burst_ilv | output | 1 | Stored burst type, 1 = interleaved |
| cas_half | output | 3 | Read latency in half-cycle ticks |
| cas_frac | output | 1 | 1 when the latency is 2.5 |
| dll_rst_req | output | 1 | One-tick pulse after a DLL-reset load |
| dll_rst_pend | output | 1 | DLL reset seen, normal load not yet seen |
| mode_err | output | 1 | One-tick pulse after a reserved load |
| speed_err | output | 1 | Frequency above the limit for the stored latency |
| rd_valid | output | 1 | Read-data-valid strobe |

## Verification
The embedded assertions check on every tick that a reserved load leaves the settings frozen, and that an error pulse and a DLL-reset pulse never occur together. They also check that the pending flag clears only after a normal load, that the burst-length output stays one of the legal values, and that the strobe never rises without a pending READ. Only the bench scenarios can show the exact tick at which the strobe rises for each latency and how long it lasts for each burst length. The same holds for seamless back-to-back bursts and for the speed flag thresholds, since each of these needs a reference count kept outside the design.

// File: rtl/ddr_mode_pkg.sv
// Shared types for the mode register controller.
// Assumes a burst code of 1..3 and a latency code of 3'b010 or 3'b110 once decoded.
package ddr_mode_pkg;

    typedef enum logic [1:0] {
        LD_NORMAL = 2'd0,
        LD_DLLRST = 2'd1,
        LD_RESV   = 2'd2
    } ld_kind_e;

    typedef struct packed {
        logic [2:0] bl_code;
        logic       ilv;
        logic       cl25;
    } mode_cfg_t;

    localparam mode_cfg_t CFG_RESET = '{bl_code: 3'b010, ilv: 1'b0, cl25: 1'b0};

    // Converts a legal burst code to a beat count.
    function automatic logic [3:0] beats_of(input logic [2:0] code);
        case (code)
            3'b001:  beats_of = 4'd2;
            3'b011:  beats_of = 4'd8;
            default: beats_of = 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/mrc_decode.sv
// Classifies a mode word as normal, DLL reset or reserved, and extracts its fields.
// Assumes that bits ADDR_W-1..7 carry the operating mode and bits 6..0 the settings.
module mrc_decode
    import ddr_mode_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] lmr_addr,
    output ld_kind_e          kind,
    output mode_cfg_t         cfg
);
    localparam int UP_W = ADDR_W - 7;
    localparam logic [UP_W-1:0] UP_DLL = UP_W'(2);

    logic [UP_W-1:0] upper;
    logic            bl_ok;
    logic            cl_ok;

    assign upper = lmr_addr[ADDR_W-1:7];

    // Field checks and classification of the upper bits.
    always_comb begin
        bl_ok = (lmr_addr[2:0] == 3'b001) || (lmr_addr[2:0] == 3'b010) ||
                (lmr_addr[2:0] == 3'b011);
        cl_ok = (lmr_addr[6:4] == 3'b010) || (lmr_addr[6:4] == 3'b110);
        if (!bl_ok || !cl_ok)       kind = LD_RESV;
        else if (upper == '0)       kind = LD_NORMAL;
        else if (upper == UP_DLL)   kind = LD_DLLRST;
        else                        kind = LD_RESV;
        cfg.bl_code = lmr_addr[2:0];
        cfg.ilv     = lmr_addr[3];
        cfg.cl25    = lmr_addr[6];
    end

endmodule

// File: rtl/mrc_mode_reg.sv
// Holds the accepted settings and produces the error, DLL request and pending flags.
// Assumes kind and cfg_in come straight from the decoder for the current lmr_addr.
module mrc_mode_reg
    import ddr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lmr_valid,
    input  ld_kind_e  kind,
    input  mode_cfg_t cfg_in,
    output mode_cfg_t cfg_q,
    output logic      mode_err,
    output logic      dll_req,
    output logic      dll_pend
);

    // Update the settings and flags on each load command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= CFG_RESET;
            mode_err <= 1'b0;
            dll_req  <= 1'b0;
            dll_pend <= 1'b0;
        end else begin
            mode_err <= 1'b0;
            dll_req  <= 1'b0;
            if (lmr_valid) begin
                case (kind)
                    LD_NORMAL: begin
                        cfg_q    <= cfg_in;
                        dll_pend <= 1'b0;
                    end
                    LD_DLLRST: begin
                        cfg_q    <= cfg_in;
                        dll_req  <= 1'b1;
                        dll_pend <= 1'b1;
                    end
                    default: mode_err <= 1'b1;
                endcase
            end
        end
    end

    // R5
    resv_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> $stable(cfg_q));

    // R6
    err_dll_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_err && dll_req));

    // R3
    dll_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dll_req |-> dll_pend);

    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dll_pend) |-> $past(lmr_valid && kind == LD_NORMAL));

endmodule

// File: rtl/mrc_rd_timer.sv
// Times the read-data-valid strobe from READ commands in half-cycle ticks.
// Assumes lat_half lies in 1..MAX_LAT and bl_beats is nonzero; settings stay steady while reads are in flight.
module mrc_rd_timer #(
    parameter int MAX_LAT = 5,
    parameter int BL_W    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_cmd,
    input  logic [2:0]      lat_half,
    input  logic [BL_W-1:0] bl_beats,
    output logic            rd_valid
);
    logic [MAX_LAT-1:0] sr;
    logic [BL_W-1:0]    cnt;
    logic               start;

    // Delay line: bit k is set k+1 ticks after a READ was sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[MAX_LAT-2:0], rd_cmd};
    end

    // Select the tap for the current latency.
    always_comb begin
        start = 1'b0;
        for (int i = 0; i < MAX_LAT; i++) begin
            if (i + 1 == int'(lat_half)) start = sr[i];
        end
    end

    // Burst counter: hold the strobe for one tick per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            cnt      <= '0;
        end else if (start) begin
            rd_valid <= 1'b1;
            cnt      <= bl_beats - BL_W'(1);
        end else if (rd_valid) begin
            if (cnt == '0) rd_valid <= 1'b0;
            else           cnt      <= cnt - BL_W'(1);
        end
    end

    // R9
    idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> cnt == '0);

    // R8
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(|sr));

endmodule

// File: rtl/ddr_mode_ctl.sv
// Top level: mode word decode, settings register, speed check and read strobe timing.
// Assumes clk runs at twice the memory clock and READs arrive on rising-edge ticks.
module ddr_mode_ctl
    import ddr_mode_pkg::*;
#(
    parameter int ADDR_W       = 14,
    parameter int FREQ_W       = 9,
    parameter int MAX_MHZ_CL2  = 133,
    parameter int MAX_MHZ_CL25 = 167,
    parameter int MAX_LAT      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lmr_valid,
    input  logic [ADDR_W-1:0] lmr_addr,
    input  logic              rd_cmd,
    input  logic [FREQ_W-1:0] freq_mhz,
    output logic [3:0]        burst_beats,
    output logic              burst_ilv,
    output logic [2:0]        cas_half,
    output logic              cas_frac,
    output logic              dll_rst_req,
    output logic              dll_rst_pend,
    output logic              mode_err,
    output logic              speed_err,
    output logic              rd_valid
);
    localparam logic [FREQ_W-1:0] LIM2  = FREQ_W'(MAX_MHZ_CL2);
    localparam logic [FREQ_W-1:0] LIM25 = FREQ_W'(MAX_MHZ_CL25);

    ld_kind_e  kind;
    mode_cfg_t cfg_new;
    mode_cfg_t cfg_q;

    mrc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .lmr_addr (lmr_addr),
        .kind     (kind),
        .cfg      (cfg_new)
    );

    mrc_mode_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .lmr_valid(lmr_valid),
        .kind     (kind),
        .cfg_in   (cfg_new),
        .cfg_q    (cfg_q),
        .mode_err (mode_err),
        .dll_req  (dll_rst_req),
        .dll_pend (dll_rst_pend)
    );

    // Derive the visible settings and the frequency limit check.
    always_comb begin
        burst_beats = beats_of(cfg_q.bl_code);
        burst_ilv   = cfg_q.ilv;
        cas_frac    = cfg_q.cl25;
        cas_half    = cfg_q.cl25 ? 3'd5 : 3'd4;
        speed_err   = freq_mhz > (cfg_q.cl25 ? LIM25 : LIM2);
    end

    mrc_rd_timer #(.MAX_LAT(MAX_LAT), .BL_W(4)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_cmd   (rd_cmd),
        .lat_half (cas_half),
        .bl_beats (burst_beats),
        .rd_valid (rd_valid)
    );

    // R2
    legal_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(burst_beats) && !burst_beats[0]);

endmodule

// File: tb/sim_ddr_mode_ctl.sv
// Bench: directed corners plus seeded random mode loads, reads and frequencies.
module sim_ddr_mode_ctl;
    localparam int ADDR_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lmr_valid = 1'b0;
    logic [ADDR_W-1:0] lmr_addr = '0;
    logic              rd_cmd = 1'b0;
    logic [8:0]        freq_mhz = 9'd100;
    logic [3:0]        burst_beats;
    logic              burst_ilv;
    logic [2:0]        cas_half;
    logic              cas_frac;
    logic              dll_rst_req;
    logic              dll_rst_pend;
    logic              mode_err;
    logic              speed_err;
    logic              rd_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model of the stored settings.
    int m_beats = 4;
    bit m_ilv   = 0;
    bit m_cl25  = 0;
    bit m_pend  = 0;

    always #5 clk = ~clk;

    ddr_mode_ctl u0 (
        .clk(clk), .rst_n(rst_n), .lmr_valid(lmr_valid), .lmr_addr(lmr_addr),
        .rd_cmd(rd_cmd), .freq_mhz(freq_mhz), .burst_beats(burst_beats),
        .burst_ilv(burst_ilv), .cas_half(cas_half), .cas_frac(cas_frac),
        .dll_rst_req(dll_rst_req), .dll_rst_pend(dll_rst_pend),
        .mode_err(mode_err), .speed_err(speed_err), .rd_valid(rd_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 0 normal, 1 DLL reset, 2 reserved
    function automatic int kind_of(input logic [ADDR_W-1:0] a);
        bit bl_ok = (a[2:0] >= 3'd1) && (a[2:0] <= 3'd3);
        bit cl_ok = (a[6:4] == 3'b010) || (a[6:4] == 3'b110);
        if (!bl_ok || !cl_ok) return 2;
        if (a[ADDR_W-1:7] == '0) return 0;
        if (a[ADDR_W-1:7] == 7'd2) return 1;
        return 2;
    endfunction

    function automatic int beats_exp(input logic [2:0] c);
        return (c == 3'd1) ? 2 : (c == 3'd2) ? 4 : 8;
    endfunction

    task automatic check_cfg(input string req);
        chk({req, " burst_beats"}, int'(burst_beats), m_beats);
        chk({req, " burst_ilv"}, int'(burst_ilv), int'(m_ilv));
        chk({"R7 ", req, " cas_half"}, int'(cas_half), m_cl25 ? 5 : 4);
        chk({"R7 ", req, " cas_frac"}, int'(cas_frac), int'(m_cl25));
        chk({"R4 ", req, " dll_rst_pend"}, int'(dll_rst_pend), int'(m_pend));
    endtask

    task automatic load(input logic [ADDR_W-1:0] a);
        int k = kind_of(a);
        @(negedge clk);
        lmr_valid = 1'b1;
        lmr_addr  = a;
        @(negedge clk);
        lmr_valid = 1'b0;
        if (k != 2) begin
            m_beats = beats_exp(a[2:0]);
            m_ilv   = a[3];
            m_cl25  = a[6];
            m_pend  = (k == 1);
        end
        chk(k == 2 ? "R5/R6 mode_err" : "R2 mode_err", int'(mode_err), int'(k == 2));
        chk("R3 dll_rst_req", int'(dll_rst_req), int'(k == 1));
        check_cfg(k == 0 ? "R2" : (k == 1 ? "R3" : "R5"));
        @(negedge clk);
        chk("R5 mode_err one tick", int'(mode_err), 0);
        chk("R3 dll_rst_req one tick", int'(dll_rst_req), 0);
    endtask

    // Issue a READ, optionally a second one gap ticks later; measure the strobe.
    task automatic do_read(input int gap);
        int lat   = m_cl25 ? 5 : 4;
        int total = (gap > 0) ? 2 * m_beats : m_beats;
        int first = -1;
        int high  = 0;
        int ends  = 0;
        bit prev  = 0;
        @(negedge clk);
        rd_cmd = 1'b1;
        @(negedge clk);
        for (int k = 0; k < lat + total + 4; k++) begin
            if (rd_valid && first < 0) first = k;
            if (rd_valid) high++;
            if (prev && !rd_valid) ends++;
            prev   = rd_valid;
            rd_cmd = (gap > 0) && (k == gap - 1);
            @(negedge clk);
        end
        rd_cmd = 1'b0;
        chk("R8 first valid tick", first, lat);
        chk(gap > 0 ? "R11 seamless length" : "R9 strobe length", high, total);
        chk(gap > 0 ? "R11 single fall" : "R9 single fall", ends, 1);
    endtask

    task automatic check_speed(input int f);
        @(negedge clk);
        freq_mhz = 9'(f);
        #1;
        chk("R10 speed_err", int'(speed_err), int'(f > (m_cl25 ? 167 : 133)));
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int up, input int cl, input bit ilv,
                                              input int bl);
        return {7'(up), 3'(cl), ilv, 3'(bl)};
    endfunction

    initial begin
        int seed;
        seed = int'($urandom(32'h0D0E_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 burst_beats", int'(burst_beats), 4);
        chk("R1 burst_ilv", int'(burst_ilv), 0);
        chk("R1 cas_half", int'(cas_half), 4);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 mode_err", int'(mode_err), 0);
        chk("R1 dll_rst_req", int'(dll_rst_req), 0);
        chk("R1 dll_rst_pend", int'(dll_rst_pend), 0);

        // Directed corners
        load(mk(0, 3'b110, 1, 3));         // R2 normal, BL8 interleaved CL2.5
        do_read(0);                         // R8 R9 at 5 ticks
        load(mk(2, 3'b010, 0, 1));         // R3 DLL reset, BL2 CL2
        do_read(0);
        load(mk(3, 3'b010, 0, 2));         // R5 reserved upper, pend kept (R4)
        load(mk(0, 3'b011, 0, 2));         // R6 reserved latency code
        load(mk(0, 3'b010, 0, 0));         // R6 reserved burst code
        load(mk(2, 3'b110, 0, 7));         // R6 DLL pattern with bad burst
        load(mk(0, 3'b010, 1, 2));         // R4 normal clears pend
        do_read(4);                         // R11 back-to-back BL4
        load(mk(0, 3'b110, 0, 1));
        do_read(2);                         // R11 at CL2.5, BL2
        check_speed(133); check_speed(167); check_speed(168);
        load(mk(0, 3'b010, 0, 3));
        check_speed(133); check_speed(134); // R10 boundaries

        // Seeded random mix
        for (int it = 0; it < 60; it++) begin
            int sel = int'($urandom % 8);
            int up  = (sel < 4) ? 0 : (sel < 6) ? 2 : int'($urandom % 128);
            int cl  = ($urandom % 4 == 0) ? int'($urandom % 8) : (($urandom % 2) ? 6 : 2);
            int bl  = ($urandom % 4 == 0) ? int'($urandom % 8) : int'(1 + $urandom % 3);
            load(mk(up, cl, 1'($urandom % 2), bl));
            if (it % 3 == 0) do_read((it % 2 == 0) ? m_beats : 0);
            check_speed(int'(100 + $urandom % 100));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule